// File: doc/BRIEF.md
# Debug Channel Interrupt Enable Register

This block is a 64-bit privileged control register belonging to a debug communications channel. It stores two enable bits. The bits combine the channel's receive-full and transmit-full status flags into one interrupt request. The receive side requests service while its buffer holds data. The transmit side requests service while its buffer has room. The interrupt output follows the flags and enables combinationally.

The register sits on a shared system-register request bus. It claims a request only when the five encoding fields match its own address. It then checks the requester's privilege level against trap controls supplied by levels 2 and 3. One cycle after the request, it returns one of three outcomes:
- a completed access, with read data or a performed write;
- an undefined-instruction outcome;
- a trap outcome, carrying a target level and a syndrome class.

Requests for other registers get no response, so a neighbouring register can answer them.

Top module: `dbg_chan_irq_ctl`

## Requirements
- R1: While rst_ni is low and after its release, both enables are 0, irq_o is 0 and rsp_valid_o is 0.
- R2: A completed read returns the receive enable on bit 30 and the transmit enable on bit 29 of rsp_rdata_o. All other bits are 0.
- R3: A completed write loads bit 30 of req_wdata_i into the receive enable and bit 29 into the transmit enable. All other written bits are discarded.
- R4: irq_o equals (receive enable AND rx_full_i) OR (transmit enable AND NOT tx_full_i), with no register delay from the flags.
- R5: A request is claimed only when op0=2, op1=0, CRn=0, CRm=2 and op2=0. Any other request gives no response and writes nothing.
- R6: A claimed request from level 0 (cur_lvl_i=0) gives rsp_kind_o=1 (undefined).
- R7: From level 1, when level 2 is enabled, not legacy, and either of its debug trap controls is set, the outcome is rsp_kind_o=2 (trap) with rsp_target_o=2. This check takes priority over R8.
- R8: Otherwise, a level-1 request traps to level 3 (rsp_target_o=3) when level 3 is present, not legacy, and its debug access trap is set. Otherwise the request completes (rsp_kind_o=0).
- R9: A level-2 request traps to level 3 under the level-3 condition of R8 and otherwise completes. A level-3 request always completes.
- R10: A trap outcome reports rsp_class_o=0x18. Completed and undefined outcomes report rsp_class_o=0 and rsp_target_o=0.
- R11: A trapped or undefined write leaves both enables unchanged. Any non-completed outcome returns rsp_rdata_o=0.
- R12: The outcome appears on the cycle after a claimed request, and rsp_valid_o is high for exactly one cycle per request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous warm reset |
| req_valid_i | input | 1 | System-register request present |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_op0_i | input | 2 | Encoding field op0 |
| req_op1_i | input | 3 | Encoding field op1 |
| req_crn_i | input | 4 | Encoding field CRn |
| req_crm_i | input | 4 | Encoding field CRm |
| req_op2_i | input | 3 | Encoding field op2 |
| req_wdata_i | input | 64 | Write data |
| cur_lvl_i | input | 2 | Privilege level of the requester |
| lvl2_enabled_i | input | 1 | Level 2 is enabled |
| lvl2_legacy_i | input | 1 | Level 2 runs in legacy mode |
| lvl2_trap_route_i | input | 1 | Level-2 debug routing trap control |
| lvl2_trap_access_i | input | 1 | Level-2 debug access trap control |
| lvl3_present_i | input | 1 | Level 3 is implemented |
| lvl3_legacy_i | input | 1 | Level 3 runs in legacy mode |
| lvl3_trap_access_i | input | 1 | Level-3 debug access trap control |
| rx_full_i | input | 1 | Receive buffer full flag |
| tx_full_i | input | 1 | Transmit buffer full flag |
| rsp_valid_o | output | 1 | One-cycle outcome strobe |
| rsp_kind_o | output | 2 | 0 completed, 1 undefined, 2 trap |
| rsp_target_o | output | 2 | Trap target level |
| rsp_class_o | output | 6 | Trap syndrome class |
| rsp_rdata_o | output | 64 | Read data |
| irq_o | output | 1 | Combined channel interrupt request |

## Verification
The assertions check these properties on every cycle:
- an outcome strobe never appears without a request in the cycle before;
- a faulting outcome never moves the enables and never returns data;
- every trap carries class 0x18 and a target of level 2 or 3;
- level-0 requests always come back undefined;
- with both enables clear, the interrupt stays low.

Only the bench's scenarios can show the following:
- the trap cascade picks the right target in each combination of controls;
- reserved write bits really vanish;
- the interrupt follows each flag with the correct polarity;
- a request for a different encoding goes unanswered and leaves the register untouched.

// File: rtl/dbg_chan_pkg.sv
package dbg_chan_pkg;
  localparam int unsigned REG_W    = 64;
  localparam int unsigned LVL_W    = 2;
  localparam int unsigned CLASS_W  = 6;
  localparam logic [CLASS_W-1:0] DBG_TRAP_CLASS = 6'h18;

  typedef enum logic [1:0] {
    RSP_OK    = 2'd0,
    RSP_UNDEF = 2'd1,
    RSP_TRAP  = 2'd2
  } rsp_kind_e;

  typedef struct packed {
    logic lvl2_enabled;
    logic lvl2_legacy;
    logic lvl2_trap_route;
    logic lvl2_trap_access;
    logic lvl3_present;
    logic lvl3_legacy;
    logic lvl3_trap_access;
  } trap_ctl_t;
endpackage

// File: rtl/dbg_chan_dec.sv
module dbg_chan_dec #(
  parameter logic [1:0] OP0 = 2'd2,
  parameter logic [2:0] OP1 = 3'd0,
  parameter logic [3:0] CRN = 4'd0,
  parameter logic [3:0] CRM = 4'd2,
  parameter logic [2:0] OP2 = 3'd0
) (
  input  logic [1:0] op0_i,
  input  logic [2:0] op1_i,
  input  logic [3:0] crn_i,
  input  logic [3:0] crm_i,
  input  logic [2:0] op2_i,
  output logic       hit_o
);
  assign hit_o = (op0_i == OP0) && (op1_i == OP1) && (crn_i == CRN) &&
                 (crm_i == CRM) && (op2_i == OP2);
endmodule

// File: rtl/dbg_chan_trap.sv
module dbg_chan_trap
  import dbg_chan_pkg::*;
(
  input  logic [LVL_W-1:0] lvl_i,
  input  trap_ctl_t        ctl_i,
  output rsp_kind_e        kind_o,
  output logic [LVL_W-1:0] target_o
);
  logic lvl2_catch, lvl3_catch;

  assign lvl2_catch = ctl_i.lvl2_enabled && !ctl_i.lvl2_legacy &&
                      (ctl_i.lvl2_trap_route || ctl_i.lvl2_trap_access);
  assign lvl3_catch = ctl_i.lvl3_present && !ctl_i.lvl3_legacy && ctl_i.lvl3_trap_access;

  // fixed priority: undefined, then level 2, then level 3
  always_comb begin
    kind_o   = RSP_OK;
    target_o = '0;
    unique case (lvl_i)
      2'd0: kind_o = RSP_UNDEF;
      2'd1: begin
        if (lvl2_catch) begin
          kind_o   = RSP_TRAP;
          target_o = 2'd2;
        end else if (lvl3_catch) begin
          kind_o   = RSP_TRAP;
          target_o = 2'd3;
        end
      end
      2'd2: begin
        if (lvl3_catch) begin
          kind_o   = RSP_TRAP;
          target_o = 2'd3;
        end
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/dbg_chan_store.sv
module dbg_chan_store #(
  parameter int unsigned DATA_W = 64,
  parameter int unsigned RX_BIT = 30,
  parameter int unsigned TX_BIT = 29
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              rx_full_i,
  input  logic              tx_full_i,
  output logic [1:0]        en_o,
  output logic              irq_o
);
  localparam int unsigned N_SRC = 2;
  localparam int unsigned SRC_BIT [N_SRC] = '{RX_BIT, TX_BIT};
  localparam bit          SRC_POL [N_SRC] = '{1'b1, 1'b0}; // level that requests service

  logic [N_SRC-1:0] en_q;
  logic [N_SRC-1:0] flag;
  logic [N_SRC-1:0] req;

  assign flag = {tx_full_i, rx_full_i};

  for (genvar i = 0; i < N_SRC; i++) begin : g_src
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)   en_q[i] <= 1'b0;
      else if (we_i) en_q[i] <= wdata_i[SRC_BIT[i]];
    end
    assign req[i] = en_q[i] && (flag[i] == SRC_POL[i]);
  end

  assign en_o  = en_q;
  assign irq_o = |req;

  a_r4_quiet_when_disabled: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_q == '0) |-> !irq_o);
  a_r1_enables_cleared: assert property (@(posedge clk_i)
    $rose(rst_ni) |-> (en_q == '0));
endmodule

// File: rtl/dbg_chan_irq_ctl.sv
module dbg_chan_irq_ctl
  import dbg_chan_pkg::*;
#(
  parameter int unsigned DATA_W = REG_W,
  parameter int unsigned RX_BIT = 30,
  parameter int unsigned TX_BIT = 29
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic              req_write_i,
  input  logic [1:0]        req_op0_i,
  input  logic [2:0]        req_op1_i,
  input  logic [3:0]        req_crn_i,
  input  logic [3:0]        req_crm_i,
  input  logic [2:0]        req_op2_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  input  logic [1:0]        cur_lvl_i,
  input  logic              lvl2_enabled_i,
  input  logic              lvl2_legacy_i,
  input  logic              lvl2_trap_route_i,
  input  logic              lvl2_trap_access_i,
  input  logic              lvl3_present_i,
  input  logic              lvl3_legacy_i,
  input  logic              lvl3_trap_access_i,
  input  logic              rx_full_i,
  input  logic              tx_full_i,
  output logic              rsp_valid_o,
  output logic [1:0]        rsp_kind_o,
  output logic [1:0]        rsp_target_o,
  output logic [5:0]        rsp_class_o,
  output logic [DATA_W-1:0] rsp_rdata_o,
  output logic              irq_o
);
  logic             hit;
  rsp_kind_e        kind;
  logic [LVL_W-1:0] target;
  trap_ctl_t        ctl;
  logic [1:0]       en;
  logic             claim, we;
  logic [DATA_W-1:0] rd_view;

  logic              rsp_valid_q;
  rsp_kind_e         rsp_kind_q;
  logic [LVL_W-1:0]  rsp_target_q;
  logic [DATA_W-1:0] rsp_rdata_q;

  assign ctl = '{lvl2_enabled:     lvl2_enabled_i,
                 lvl2_legacy:      lvl2_legacy_i,
                 lvl2_trap_route:  lvl2_trap_route_i,
                 lvl2_trap_access: lvl2_trap_access_i,
                 lvl3_present:     lvl3_present_i,
                 lvl3_legacy:      lvl3_legacy_i,
                 lvl3_trap_access: lvl3_trap_access_i};

  dbg_chan_dec u_dec (
    .op0_i (req_op0_i),
    .op1_i (req_op1_i),
    .crn_i (req_crn_i),
    .crm_i (req_crm_i),
    .op2_i (req_op2_i),
    .hit_o (hit)
  );

  dbg_chan_trap u_trap (
    .lvl_i    (cur_lvl_i),
    .ctl_i    (ctl),
    .kind_o   (kind),
    .target_o (target)
  );

  assign claim = req_valid_i && hit;
  assign we    = claim && req_write_i && (kind == RSP_OK);

  dbg_chan_store #(.DATA_W(DATA_W), .RX_BIT(RX_BIT), .TX_BIT(TX_BIT)) u_store (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .we_i      (we),
    .wdata_i   (req_wdata_i),
    .rx_full_i (rx_full_i),
    .tx_full_i (tx_full_i),
    .en_o      (en),
    .irq_o     (irq_o)
  );

  always_comb begin
    rd_view         = '0;
    rd_view[RX_BIT] = en[0];
    rd_view[TX_BIT] = en[1];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_q  <= 1'b0;
      rsp_kind_q   <= RSP_OK;
      rsp_target_q <= '0;
      rsp_rdata_q  <= '0;
    end else begin
      rsp_valid_q <= claim;
      if (claim) begin
        rsp_kind_q   <= kind;
        rsp_target_q <= target;
        rsp_rdata_q  <= (kind == RSP_OK && !req_write_i) ? rd_view : '0;
      end
    end
  end

  assign rsp_valid_o  = rsp_valid_q;
  assign rsp_kind_o   = rsp_kind_q;
  assign rsp_target_o = rsp_target_q;
  assign rsp_class_o  = (rsp_kind_q == RSP_TRAP) ? DBG_TRAP_CLASS : '0;
  assign rsp_rdata_o  = rsp_rdata_q;

  a_r12_rsp_needs_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |-> $past(req_valid_i));
  a_r11_fault_keeps_state: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && rsp_kind_o != RSP_OK) |-> $stable(en));
  a_r11_fault_no_data: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && rsp_kind_o != RSP_OK) |-> (rsp_rdata_o == '0));
  a_r10_trap_syndrome: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && rsp_kind_o == RSP_TRAP) |-> (rsp_class_o == 6'h18 && rsp_target_o[1]));
  a_r6_lvl0_undef: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (claim && cur_lvl_i == 2'd0) |=> (rsp_valid_o && rsp_kind_o == RSP_UNDEF));
  a_r3_write_lands: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we |=> (en == {$past(req_wdata_i[TX_BIT]), $past(req_wdata_i[RX_BIT])}));
endmodule

// File: tb/sim_dbg_chan_irq_ctl.sv
`timescale 1ns/1ps
module sim_dbg_chan_irq_ctl;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_valid_i = 1'b0, req_write_i = 1'b0;
  logic [1:0]  req_op0_i = '0;
  logic [2:0]  req_op1_i = '0;
  logic [3:0]  req_crn_i = '0;
  logic [3:0]  req_crm_i = '0;
  logic [2:0]  req_op2_i = '0;
  logic [63:0] req_wdata_i = '0;
  logic [1:0]  cur_lvl_i = '0;
  logic [6:0]  ctl = '0; // {l3acc,l3leg,l3p,l2acc,l2route,l2leg,l2en}
  logic        rx_full_i = 1'b0, tx_full_i = 1'b0;
  logic        rsp_valid_o, irq_o;
  logic [1:0]  rsp_kind_o, rsp_target_o;
  logic [5:0]  rsp_class_o;
  logic [63:0] rsp_rdata_o;

  int unsigned n_cmp = 0, n_bad = 0;
  bit m_rx = 0, m_tx = 0;
  bit done = 0;

  always #2 clk_i = ~clk_i;

  dbg_chan_irq_ctl u0 (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .req_valid_i(req_valid_i), .req_write_i(req_write_i),
    .req_op0_i(req_op0_i), .req_op1_i(req_op1_i), .req_crn_i(req_crn_i),
    .req_crm_i(req_crm_i), .req_op2_i(req_op2_i), .req_wdata_i(req_wdata_i),
    .cur_lvl_i(cur_lvl_i),
    .lvl2_enabled_i(ctl[0]), .lvl2_legacy_i(ctl[1]), .lvl2_trap_route_i(ctl[2]),
    .lvl2_trap_access_i(ctl[3]), .lvl3_present_i(ctl[4]), .lvl3_legacy_i(ctl[5]),
    .lvl3_trap_access_i(ctl[6]),
    .rx_full_i(rx_full_i), .tx_full_i(tx_full_i),
    .rsp_valid_o(rsp_valid_o), .rsp_kind_o(rsp_kind_o), .rsp_target_o(rsp_target_o),
    .rsp_class_o(rsp_class_o), .rsp_rdata_o(rsp_rdata_o), .irq_o(irq_o)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [3:0] exp_outcome(input logic [1:0] lvl, input logic [6:0] c);
    logic l2, l3;
    l2 = c[0] && !c[1] && (c[2] || c[3]);
    l3 = c[4] && !c[5] && c[6];
    if (lvl == 2'd0) return {2'd1, 2'd0};
    if (lvl == 2'd1 && l2) return {2'd2, 2'd2};
    if (lvl != 2'd3 && l3) return {2'd2, 2'd3};
    return {2'd0, 2'd0};
  endfunction

  function automatic logic exp_irq(input bit rx, input bit tx);
    return (m_rx && rx) || (m_tx && !tx);
  endfunction

  task automatic check_irq(input bit rx, input bit tx);
    rx_full_i = rx;
    tx_full_i = tx;
    #0.5;
    check("R4 irq", irq_o, exp_irq(rx, tx));
  endtask

  // one request at a negedge, outcome checked one edge later, strobe end one edge after
  task automatic xact(input bit wr, input bit match, input logic [63:0] wd,
                      input logic [1:0] lvl, input logic [6:0] c);
    logic [3:0] eo;
    int unsigned f;
    req_valid_i = 1'b1; req_write_i = wr; req_wdata_i = wd;
    cur_lvl_i = lvl; ctl = c;
    req_op0_i = 2'd2; req_op1_i = 3'd0; req_crn_i = 4'd0; req_crm_i = 4'd2; req_op2_i = 3'd0;
    if (!match) begin
      f = $urandom % 5;
      case (f)
        0: req_op0_i = req_op0_i ^ 2'(1 + $urandom % 3);
        1: req_op1_i = req_op1_i ^ 3'(1 + $urandom % 7);
        2: req_crn_i = req_crn_i ^ 4'(1 + $urandom % 15);
        3: req_crm_i = req_crm_i ^ 4'(1 + $urandom % 15);
        default: req_op2_i = req_op2_i ^ 3'(1 + $urandom % 7);
      endcase
    end
    eo = exp_outcome(lvl, c);
    @(negedge clk_i);
    if (!match) begin
      check("R5 no response to foreign encoding", rsp_valid_o, 0);
    end else begin
      check("R12 outcome strobe", rsp_valid_o, 1);
      check("R6 R7 R8 R9 outcome kind", rsp_kind_o, eo[3:2]);
      check("R7 R8 R9 trap target", rsp_target_o, eo[1:0]);
      check("R10 syndrome class", rsp_class_o, (eo[3:2] == 2'd2) ? 6'h18 : 6'h0);
      if (eo[3:2] != 2'd0)
        check("R11 fault read data zero", rsp_rdata_o, 0);
      else if (!wr)
        check("R2 read data", rsp_rdata_o, {33'b0, m_rx, m_tx, 29'b0});
      if (wr && eo[3:2] == 2'd0) begin
        m_rx = wd[30];
        m_tx = wd[29];
      end
    end
    req_valid_i = 1'b0;
    @(negedge clk_i);
    check("R12 strobe single cycle", rsp_valid_o, 0);
  endtask

  task automatic read_back(input string req);
    xact(0, 1, '0, 2'd3, 7'h7f);
    check(req, {m_rx, m_tx}, {m_rx, m_tx});
  endtask

  initial begin
    #(4 * 150000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_0c0d));
    #10;
    check("R1 strobe in reset", rsp_valid_o, 0);
    check("R1 irq in reset", irq_o, 0);
    @(negedge clk_i); rst_ni = 1'b1;
    @(negedge clk_i);
    check("R1 irq after reset, tx not full", irq_o, 0);
    xact(0, 1, '0, 2'd3, '0); // R1 read: enables zero

    // R3: only bits 30/29 retained
    xact(1, 1, 64'hffff_ffff_ffff_ffff, 2'd3, '0);
    xact(0, 1, '0, 2'd3, '0);
    check_irq(1, 1); check_irq(0, 0); check_irq(0, 1);
    xact(1, 1, 64'hbfff_ffff_dfff_ffff & ~64'h0000_0000_6000_0000 | 64'h4000_0000, 2'd1, '0);
    xact(0, 1, '0, 2'd2, '0);
    check_irq(1, 1); check_irq(0, 0);

    // R11: trapped and undefined writes keep state
    xact(1, 1, 64'h0, 2'd1, 7'b0000101); // trap to 2
    xact(1, 1, 64'h0, 2'd0, 7'b0000000); // undefined
    xact(1, 1, 64'h0, 2'd2, 7'b1010000); // trap to 3
    read_back("R11 state kept");
    // R7 priority over level-3 trap
    xact(0, 1, '0, 2'd1, 7'b1011001);
    // R8 legacy level 2 falls through to level 3
    xact(0, 1, '0, 2'd1, 7'b1011111);
    // R9 level 3 ignores all traps
    xact(1, 1, 64'h2000_0000, 2'd3, 7'h7f);
    // R5 foreign encoding write must not land
    xact(1, 0, 64'h6000_0000, 2'd3, '0);
    read_back("R5 no write");
    check_irq(1, 0); check_irq(0, 1);

    for (int i = 0; i < 400; i++) begin
      bit wr, mt;
      logic [63:0] wd;
      wr = $urandom % 2;
      mt = ($urandom % 4) != 0;
      wd = {$urandom, $urandom};
      xact(wr, mt, wd, 2'($urandom % 4), 7'($urandom));
      check_irq($urandom % 2, $urandom % 2);
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule